// File: doc/BRIEF.md
# Serial Clocked Wiper Stepper

This block drives fine adjustment of a digital potentiometer wiper straight from the two-wire bus lines. The instruction decoder recognises an increment/decrement instruction and acknowledges it. It then pulses `arm_i` once and presents the wiper select on `sel_i`. From that point on, no data bytes and no acknowledges are exchanged. Each SCL pulse moves the selected wiper code by one tap. The direction comes from the level of SDA during the pulse: high steps toward the high terminal (code + 1) and low steps toward the low terminal (code − 1).

The wiper register file is outside the block. The block shows the selected wiper on `sel_o`, reads that wiper's code back on `cur_code_i`, and issues single-cycle write updates. The code saturates at both ends of its range and never wraps. Stepping ends at a stop condition or at a repeated start. A repeated start hands control back to the slave front end through `restart_o`. Stepping only changes the volatile wiper code. It never starts a non-volatile programming cycle.

Top module: `wiper_stepper`

## Requirements
- R1: After reset `active_o`, `wr_en_o` and `restart_o` are 0, and SCL pulses change no wiper until `arm_i` has been seen.
- R2: A one-cycle `arm_i` latches `sel_i` onto `sel_o`. Only that wiper is written until the mode ends.
- R3: A full SCL pulse (low-high-low) during which SDA stays high raises the selected code by one.
- R4: A full SCL pulse during which SDA stays low lowers the selected code by one.
- R5: The code saturates. A raising step at 255 leaves 255, and a lowering step at 0 leaves 0, with no write issued.
- R6: Exactly one step is applied per SCL pulse. It is applied on the SCL falling edge, and `wr_en_o` is never high in two consecutive cycles.
- R7: `stop_i`, or SDA rising while SCL is high, clears `active_o` and applies no step for that pulse. Later SCL pulses change nothing.
- R8: SDA falling while SCL is high (a repeated start) clears `active_o` and applies no step. `restart_o` goes high for exactly one cycle.
- R9: In one frame, any number of steps may be given in any mix of directions. Each step is applied to the latest code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Synchronised serial clock line |
| sda_i | input | 1 | Synchronised serial data line |
| arm_i | input | 1 | One-cycle pulse from the decoder after the instruction acknowledge |
| sel_i | input | SEL_W | Wiper select given with `arm_i` |
| stop_i | input | 1 | Stop condition strobe from the front end |
| cur_code_i | input | CODE_W | Current code of the wiper shown on `sel_o` |
| active_o | output | 1 | Stepping mode in progress |
| sel_o | output | SEL_W | Latched wiper select |
| wr_en_o | output | 1 | One-cycle write strobe for a new wiper code |
| wr_sel_o | output | SEL_W | Wiper to write |
| wr_code_o | output | CODE_W | New wiper code |
| restart_o | output | 1 | One-cycle pulse: a repeated start ended stepping |

## Verification
A wrong captured direction or a lost pending flag shows up in the wiper code within a few clocks of the SCL falling edge that should have stepped it. A missed saturation shows as a jump from 255 to 0, or from 0 to 255, on the first step past the end of the range. A state machine that fails to leave the mode on a stop or a repeated start shows up at the next SCL pulse, as a code change where none is expected and as `active_o` still high. A wrong select latch corrupts the other wiper on the first step.

// File: rtl/wiper_stepper_pkg.sv
package wiper_stepper_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2
  } step_state_e;
endpackage

// File: rtl/line_edges.sv
module line_edges #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] line_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '1;  // idle bus lines sit high
    else         prev_q <= line_i;
  end

  for (genvar i = 0; i < N; i++) begin : g_edge
    assign rise_o[i] = line_i[i] & ~prev_q[i];
    assign fall_o[i] = ~line_i[i] & prev_q[i];
  end
endmodule

// File: rtl/sat_step.sv
module sat_step #(
  parameter int CODE_W = 8
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic              up_i,
  output logic [CODE_W-1:0] code_o,
  output logic              moved_o
);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;

  always_comb begin
    code_o  = code_i;
    moved_o = 1'b0;
    if (up_i && code_i != CODE_MAX) begin
      code_o  = code_i + 1'b1;
      moved_o = 1'b1;
    end else if (!up_i && code_i != '0) begin
      code_o  = code_i - 1'b1;
      moved_o = 1'b1;
    end
  end
endmodule

// File: rtl/step_fsm.sv
module step_fsm
  import wiper_stepper_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int SEL_W  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_rise_i,
  input  logic              sda_fall_i,
  input  logic              arm_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              stop_i,
  input  logic [CODE_W-1:0] nxt_code_i,
  input  logic              moved_i,
  output logic              dir_up_o,
  output logic              active_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic              wr_en_o,
  output logic [SEL_W-1:0]  wr_sel_o,
  output logic [CODE_W-1:0] wr_code_o,
  output logic              restart_o
);
  step_state_e state_q;
  logic        dir_q;
  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      dir_q     <= 1'b0;
      sel_q     <= '0;
      wr_en_o   <= 1'b0;
      wr_sel_o  <= '0;
      wr_code_o <= '0;
      restart_o <= 1'b0;
    end else begin
      wr_en_o   <= 1'b0;
      restart_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (arm_i) begin
          sel_q   <= sel_i;
          state_q <= ST_LOW;
        end
        ST_LOW: begin
          if (stop_i) state_q <= ST_IDLE;
          else if (scl_rise_i) begin
            dir_q   <= sda_i;  // direction sampled on SCL rise
            state_q <= ST_HIGH;
          end
        end
        ST_HIGH: begin
          if (stop_i || sda_rise_i) state_q <= ST_IDLE;
          else if (sda_fall_i) begin
            restart_o <= 1'b1;
            state_q   <= ST_IDLE;
          end else if (scl_fall_i) begin
            wr_en_o   <= moved_i;
            wr_sel_o  <= sel_q;
            wr_code_o <= nxt_code_i;
            state_q   <= ST_LOW;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign dir_up_o = dir_q;
  assign active_o = (state_q != ST_IDLE);
  assign sel_o    = sel_q;
endmodule

// File: rtl/wiper_stepper.sv
module wiper_stepper #(
  parameter int NUM_WIPERS = 2,
  parameter int CODE_W     = 8,
  localparam int SEL_W     = (NUM_WIPERS > 1) ? $clog2(NUM_WIPERS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              arm_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              stop_i,
  input  logic [CODE_W-1:0] cur_code_i,
  output logic              active_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic              wr_en_o,
  output logic [SEL_W-1:0]  wr_sel_o,
  output logic [CODE_W-1:0] wr_code_o,
  output logic              restart_o
);
  logic [1:0] rise, fall;  // [1]=scl [0]=sda
  logic [CODE_W-1:0] nxt_code;
  logic moved, dir_up;

  line_edges #(.N(2)) u_edges (
    .clk_i, .rst_ni,
    .line_i ({scl_i, sda_i}),
    .rise_o (rise),
    .fall_o (fall)
  );

  sat_step #(.CODE_W(CODE_W)) u_sat (
    .code_i  (cur_code_i),
    .up_i    (dir_up),
    .code_o  (nxt_code),
    .moved_o (moved)
  );

  step_fsm #(.CODE_W(CODE_W), .SEL_W(SEL_W)) u_fsm (
    .clk_i, .rst_ni, .sda_i,
    .scl_rise_i (rise[1]),
    .scl_fall_i (fall[1]),
    .sda_rise_i (rise[0]),
    .sda_fall_i (fall[0]),
    .arm_i, .sel_i, .stop_i,
    .nxt_code_i (nxt_code),
    .moved_i    (moved),
    .dir_up_o   (dir_up),
    .active_o, .sel_o, .wr_en_o, .wr_sel_o, .wr_code_o, .restart_o
  );
endmodule

// File: rtl/wiper_stepper_chk.sv
module wiper_stepper_chk #(
  parameter int CODE_W = 8,
  parameter int SEL_W  = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CODE_W-1:0] cur_code_i,
  input logic              active_o,
  input logic [SEL_W-1:0]  sel_o,
  input logic              wr_en_o,
  input logic [CODE_W-1:0] wr_code_o,
  input logic              restart_o
);
  // R3 R4 R5: each write is a single-tap move from the code read back
  a_r5_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> ({1'b0, wr_code_o} == {1'b0, $past(cur_code_i)} + 1'b1) ||
                ({1'b0, $past(cur_code_i)} == {1'b0, wr_code_o} + 1'b1));

  // R6: one step per pulse
  a_r6_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o);

  // R1 R7: no write without the mode active in the cycle before
  a_r7_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(active_o) |-> !wr_en_o);

  // R8: restart leaves the mode
  a_r8_restart_exits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |-> !active_o && $fell(active_o));

  // R2: select holds for the whole frame
  a_r2_sel_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && $past(active_o)) |-> $stable(sel_o));
endmodule

bind wiper_stepper wiper_stepper_chk #(.CODE_W(CODE_W), .SEL_W(SEL_W)) u_chk (
  .clk_i, .rst_ni, .cur_code_i, .active_o, .sel_o, .wr_en_o, .wr_code_o, .restart_o
);

// File: tb/wiper_stepper_tb.sv
module wiper_stepper_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1, arm = 1'b0, stop = 1'b0;
  logic [0:0] sel = '0;
  logic [7:0] cur_code;
  logic active, wr_en, restart;
  logic [0:0] sel_out, wr_sel;
  logic [7:0] wr_code;
  logic [7:0] w [2];
  int checks = 0, errors = 0, restarts = 0, writes = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wiper_stepper u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda), .arm_i(arm),
    .sel_i(sel), .stop_i(stop), .cur_code_i(cur_code), .active_o(active),
    .sel_o(sel_out), .wr_en_o(wr_en), .wr_sel_o(wr_sel), .wr_code_o(wr_code),
    .restart_o(restart)
  );

  // register file model
  assign cur_code = w[sel_out];
  always @(posedge clk) begin
    if (wr_en) begin w[wr_sel] <= wr_code; writes++; end
    if (restart) restarts++;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(bit up);
    sda = up; wait_clk(3);
    scl = 1'b1; wait_clk(3);
    scl = 1'b0; wait_clk(3);
  endtask

  task automatic do_arm(bit s);
    sel = s; arm = 1'b1; wait_clk(1);
    arm = 1'b0; wait_clk(2);
  endtask

  task automatic t_reset;
    chk("R1 active", active, 0);
    chk("R1 wr_en", wr_en, 0);
    chk("R1 restart", restart, 0);
    scl = 1'b0; wait_clk(2);
    pulse(1); pulse(0);
    chk("R1 no step before arm w0", w[0], 100);
    chk("R1 no step before arm w1", w[1], 200);
  endtask

  task automatic t_up_down;
    do_arm(1);
    chk("R2 active", active, 1);
    chk("R2 sel latched", sel_out, 1);
    for (int i = 0; i < 3; i++) pulse(1);
    chk("R3 increment", w[1], 203);
    chk("R2 other wiper untouched", w[0], 100);
    for (int i = 0; i < 5; i++) pulse(0);
    chk("R4 decrement", w[1], 198);
    writes = 0; pulse(1);
    chk("R6 one write per pulse", writes, 1);
    chk("R6 step value", w[1], 199);
  endtask

  task automatic t_mix;
    // R9: +1 +1 -1 +1 -1 -1 -1 from 199
    pulse(1); pulse(1); pulse(0); pulse(1); pulse(0); pulse(0); pulse(0);
    chk("R9 mixed sequence", w[1], 198);
  endtask

  task automatic t_saturate;
    w[1] = 8'd254;
    pulse(1); pulse(1); pulse(1);
    chk("R5 top saturate", w[1], 255);
    w[1] = 8'd1;
    writes = 0;
    pulse(0); pulse(0); pulse(0);
    chk("R5 bottom saturate", w[1], 0);
    chk("R5 single write at floor", writes, 1);
  endtask

  task automatic t_stop_strobe;
    w[1] = 8'd50;
    stop = 1'b1; wait_clk(1); stop = 1'b0; wait_clk(2);
    chk("R7 stop strobe exits", active, 0);
    pulse(1); pulse(0);
    chk("R7 pulses ignored after stop", w[1], 50);
  endtask

  task automatic t_stop_lines;
    do_arm(0);
    pulse(1);
    chk("R3 wiper0 step", w[0], 101);
    sda = 1'b0; wait_clk(3);
    scl = 1'b1; wait_clk(3);
    sda = 1'b1; wait_clk(3);  // stop on the lines
    chk("R7 line stop exits", active, 0);
    chk("R7 no step on stop pulse", w[0], 101);
    scl = 1'b0; wait_clk(2);
    pulse(0);
    chk("R7 idle after line stop", w[0], 101);
  endtask

  task automatic t_restart;
    do_arm(0);
    restarts = 0;
    sda = 1'b1; wait_clk(3);
    scl = 1'b1; wait_clk(3);
    sda = 1'b0; wait_clk(3);  // repeated start
    chk("R8 restart exits", active, 0);
    chk("R8 restart single pulse", restarts, 1);
    chk("R8 no step on restart", w[0], 101);
    scl = 1'b0; wait_clk(2);
    pulse(1);
    chk("R8 idle after restart", w[0], 101);
  endtask

  initial begin
    w[0] = 8'd100; w[1] = 8'd200;
    wait_clk(3); rst_n = 1'b1; wait_clk(2);
    t_reset();
    t_up_down();
    t_mix();
    t_saturate();
    t_stop_strobe();
    t_stop_lines();
    t_restart();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule